// File: doc/BRIEF.md
# Cascade Page Address Enumeration Chain

This block models a row of identical device slices wired in a fixed priority order, with slice 0 highest. Each slice holds a page address field and an active-low full flag. Because the slices start out identical, none can be reached through a device-select register alone. They are given distinct addresses by broadcast commands that every slice sees at once.

A write-page command carries a value. Only the highest-priority slice whose flag still shows empty takes that value. That slice then marks itself full, so the next write-page command falls through to the next empty slice down the chain. A clear-full command returns every flag to empty and keeps the stored addresses. Each slice is a two-state machine with the states SLICE_EMPTY and SLICE_FULL. Its transitions are named ACCEPT (SLICE_EMPTY to SLICE_FULL, on a write granted by the chain) and RELEASE (SLICE_FULL to SLICE_EMPTY, on clear-full). The command decoder is purely combinational.

Top module: `page_enum_chain`

## Requirements
- R1: While reset is low and on the first cycle after it, every page address reads 0, every full_n bit reads 1 (empty) and overflow reads 0.
- R2: A write-page command (cmd_valid=1, cmd_op=2'b01) stores cmd_data into the lowest-numbered slice whose full_n is 1. The new value shows on page_addr bits [i*PA_W +: PA_W] after the clock edge that samples the command.
- R3: At that same edge the accepting slice's full_n goes to 0. No other slice changes its flag or address.
- R4: Successive write-page commands land on successively higher-numbered empty slices. At most one full_n bit falls in any cycle.
- R5: A clear-full command (cmd_valid=1, cmd_op=2'b10) sets every full_n bit to 1 at the next edge and leaves every page address unchanged.
- R6: A write-page command issued while every full_n bit is 0 changes no flag and no address. It raises overflow for exactly the one cycle after that edge.
- R7: Idle cycles change no flag and no address. An idle cycle is one with cmd_valid=0, or with cmd_op equal to 2'b00 or 2'b11.
- R8: overflow is 0 after every cycle that did not carry a write-page command into a fully occupied chain.
- R9: After a clear-full, a new enumeration starts again at slice 0 and overwrites the addresses stored earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Broadcast command present this cycle |
| cmd_op | input | 2 | 00 idle, 01 write-page, 10 clear-full, 11 idle |
| cmd_data | input | PA_W | Page address carried by write-page |
| page_addr | output | NUM_SLICES*PA_W | Stored page address of each slice, slice i at [i*PA_W +: PA_W] |
| full_n | output | NUM_SLICES | Per-slice active-low full flag |
| overflow | output | 1 | Write-page found no empty slice (one-cycle pulse) |

## Verification
A wrong slice state shows at the ports on the edge right after the command that caused it. It appears as a flag that failed to fall, a flag that fell in a second slice, or an address written into the wrong field. A broken priority ripple leaves a gap or a double write. This stays hidden until the enumeration passes the faulty slice, so the bench compares every field after every command. It also runs a full enumeration, a write into a full chain, a clear-full, a re-enumeration, and a long random mix of all opcodes.

// File: rtl/page_enum_pkg.sv
package page_enum_pkg;

    typedef enum logic [1:0] {
        OP_IDLE     = 2'b00,
        OP_WR_PAGE  = 2'b01,
        OP_CLR_FULL = 2'b10,
        OP_RSVD     = 2'b11
    } cmd_op_e;

    typedef enum logic {
        SLICE_EMPTY = 1'b0,
        SLICE_FULL  = 1'b1
    } slice_state_e;

endpackage

// File: rtl/page_enum_cmd_decode.sv
module page_enum_cmd_decode
    import page_enum_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic       wr_req,
    output logic       clr_req
);
    cmd_op_e op;

    always_comb begin
        op      = cmd_op_e'(cmd_op);
        wr_req  = 1'b0;
        clr_req = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_WR_PAGE:  wr_req  = 1'b1;
                OP_CLR_FULL: clr_req = 1'b1;
                OP_IDLE,
                OP_RSVD:     ;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/page_enum_priority.sv
module page_enum_priority #(
    parameter int NUM_SLICES = 8
) (
    input  logic                  wr_req,
    input  logic [NUM_SLICES-1:0] empty,
    output logic [NUM_SLICES-1:0] grant,
    output logic                  all_full
);
    // pass[i] is high when every slice above i (lower index) is full
    logic [NUM_SLICES:0] pass;

    assign pass[0] = 1'b1;

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_link
        assign pass[i+1] = pass[i] & ~empty[i];
        assign grant[i]  = wr_req & pass[i] & empty[i];
    end

    assign all_full = pass[NUM_SLICES];
endmodule

// File: rtl/page_enum_slice.sv
module page_enum_slice
    import page_enum_pkg::*;
#(
    parameter int PA_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            grant,
    input  logic            clr_req,
    input  logic [PA_W-1:0] wr_data,
    output logic            empty,
    output logic [PA_W-1:0] page
);
    slice_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLICE_EMPTY;
        else        state_q <= state_d;
    end

    // next state: ACCEPT and RELEASE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLICE_EMPTY: if (grant)   state_d = SLICE_FULL;
            SLICE_FULL:  if (clr_req) state_d = SLICE_EMPTY;
            default:                  state_d = SLICE_EMPTY;
        endcase
    end

    // page field is loaded only on ACCEPT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              page <= '0;
        else if (state_q == SLICE_EMPTY && grant) page <= wr_data;
    end

    // outputs
    always_comb begin
        empty = (state_q == SLICE_EMPTY);
    end
endmodule

// File: rtl/page_enum_chain.sv
module page_enum_chain
    import page_enum_pkg::*;
#(
    parameter int NUM_SLICES = 8,
    parameter int PA_W       = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [1:0]                 cmd_op,
    input  logic [PA_W-1:0]            cmd_data,
    output logic [NUM_SLICES*PA_W-1:0] page_addr,
    output logic [NUM_SLICES-1:0]      full_n,
    output logic                       overflow
);
    logic                  wr_req;
    logic                  clr_req;
    logic [NUM_SLICES-1:0] empty;
    logic [NUM_SLICES-1:0] grant;
    logic                  all_full;

    page_enum_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .wr_req    (wr_req),
        .clr_req   (clr_req)
    );

    page_enum_priority #(.NUM_SLICES(NUM_SLICES)) u_prio (
        .wr_req   (wr_req),
        .empty    (empty),
        .grant    (grant),
        .all_full (all_full)
    );

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        page_enum_slice #(.PA_W(PA_W)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .grant   (grant[i]),
            .clr_req (clr_req),
            .wr_data (cmd_data),
            .empty   (empty[i]),
            .page    (page_addr[i*PA_W +: PA_W])
        );
    end

    always_comb begin
        full_n = empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) overflow <= 1'b0;
        else        overflow <= wr_req & all_full;
    end
endmodule

// File: rtl/page_enum_chain_chk.sv
module page_enum_chain_chk #(
    parameter int NUM_SLICES = 8,
    parameter int PA_W       = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cmd_valid,
    input logic [1:0]                 cmd_op,
    input logic [PA_W-1:0]            cmd_data,
    input logic [NUM_SLICES*PA_W-1:0] page_addr,
    input logic [NUM_SLICES-1:0]      full_n,
    input logic                       overflow
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    wire is_wr  = cmd_valid && (cmd_op == 2'b01);
    wire is_clr = cmd_valid && (cmd_op == 2'b10);

    assert_first_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(is_wr) && $past(full_n[0]))
        |-> (!full_n[0] && page_addr[PA_W-1:0] == $past(cmd_data)));

    assert_one_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ($countones($past(full_n) & ~full_n) <= 1));

    assert_fill_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(is_wr) && $past(|full_n))
        |-> ($countones(~full_n) == $countones(~$past(full_n)) + 1));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(is_clr)) |-> ((&full_n) && $stable(page_addr)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && overflow) |-> (full_n == '0 && $stable(full_n) && $stable(page_addr)));

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(is_wr) && !$past(is_clr)) |-> ($stable(full_n) && $stable(page_addr)));

    assert_ovf_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(is_wr)) |-> !overflow);
endmodule

bind page_enum_chain page_enum_chain_chk #(.NUM_SLICES(NUM_SLICES), .PA_W(PA_W)) u_chk (.*);

// File: tb/page_enum_chain_tb.sv
module page_enum_chain_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int PW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic [PW-1:0]     cmd_data = '0;
    logic [N*PW-1:0]   page_addr;
    logic [N-1:0]      full_n;
    logic              overflow;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [PW-1:0] m_pa [N];
    logic [N-1:0]  m_full_n;
    logic          m_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_enum_chain #(.NUM_SLICES(N), .PA_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .page_addr(page_addr), .full_n(full_n), .overflow(overflow)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // lowest empty slice index, N if none
    function automatic int first_empty(input logic [N-1:0] fn);
        for (int i = N-1; i >= 0; i--) ;
        for (int i = 0; i < N; i++) if (fn[i]) return i;
        return N;
    endfunction

    task automatic model_step(input logic v, input logic [1:0] op, input logic [PW-1:0] d);
        int k;
        m_ovf = 1'b0;
        if (v && op == 2'b01) begin
            k = first_empty(m_full_n);
            if (k == N) m_ovf = 1'b1;
            else begin
                m_pa[k] = d;
                m_full_n[k] = 1'b0;
            end
        end else if (v && op == 2'b10) begin
            m_full_n = '1;
        end
    endtask

    task automatic compare_all(input string tag);
        for (int i = 0; i < N; i++)
            chk(tag, 32'(page_addr[i*PW +: PW]), 32'(m_pa[i]));
        chk(tag, 32'(full_n), 32'(m_full_n));
        chk(tag, 32'(overflow), 32'(m_ovf));
    endtask

    task automatic step(input logic v, input logic [1:0] op, input logic [PW-1:0] d, input string tag);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_data = d;
        model_step(v, op, d);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
        compare_all(tag);
        // an idle cycle follows every command, so overflow must clear
        model_step(1'b0, 2'b00, '0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_pa[i] = '0;
        m_full_n = '1;
        m_ovf = 1'b0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        compare_all("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1 after reset");

        // R2 R3 R4: enumerate every slice with distinct values
        for (int i = 0; i < N; i++) step(1'b1, 2'b01, PW'(i + 3), "R2/R3/R4 enumerate");
        // R6: write into a full chain
        step(1'b1, 2'b01, 4'hF, "R6 overflow write");
        @(negedge clk);
        compare_all("R8 overflow drops");
        // R7: idle and reserved opcodes, and valid low
        step(1'b1, 2'b11, 4'hA, "R7 reserved op");
        step(1'b0, 2'b01, 4'hA, "R7 valid low");
        step(1'b1, 2'b00, 4'hA, "R7 idle op");
        // R5: clear keeps addresses
        step(1'b1, 2'b10, 4'h0, "R5 clear full");
        // R9: re-enumerate from slice 0
        for (int i = 0; i < N; i++) step(1'b1, 2'b01, PW'(N - i), "R9 re-enumerate");

        // random mix, write-page weighted
        for (int t = 0; t < 600; t++) begin
            int r = int'($urandom_range(9, 0));
            logic [1:0] op = (r < 6) ? 2'b01 : (r < 7) ? 2'b10 : (r < 8) ? 2'b00 : 2'b11;
            step(($urandom_range(7, 0) != 0), op, PW'($urandom), "R2/R5/R6/R7 random");
        end

        // reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < N; i++) m_pa[i] = '0;
        m_full_n = '1; m_ovf = 1'b0;
        @(negedge clk);
        compare_all("R1 second reset");
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule